// File: doc/BRIEF.md
# RAM Built-In Self-Test Engine

This block tests a single-port synchronous RAM of 2^ADDR_W words of DATA_W bits (32K x 16 by default) under the control of one 16-bit test-control register. The host writes a test code and a start bit. The engine then takes over the RAM port and sweeps memory with fills and read-backs. When the sweep ends it reports pass or fail in two result bits. Every test is destructive: the old RAM contents are lost.

When no test is running, the RAM port follows the host's own access port. Words below a protected boundary have some bits that the host cannot write, unless the full-access bit is set. A forced-failure bit proves that the checker works. After master reset the engine runs the increment/decrement test by itself.

Top module: `ram_selftest`

## Requirements
- R1: The control register reads {full_access[15], force_fail[14], mode[13:11], run[10], pass[9], fail[8], 8'h00}. While rst_n is low it reads 16'h0000 and the engine makes no RAM write.
- R2: A host write with bit 10 set and a mode from 001 to 110 starts a test. Bits 9:8 clear and bit 10 reads 1. When the test completes, bit 10 clears and exactly one of pass (bit 9) or fail (bit 8) is set.
- R3: A start with mode 000 or 111 does nothing. Bit 10 reads 0, bits 9:8 keep their old values, and no RAM access is made.
- R4: Single-pass modes: 010 writes 0x0000 everywhere, 011 checks for 0x0000 everywhere, 100 writes 0xFFFF everywhere, and 101 checks for 0xFFFF everywhere. Each pass runs in ascending address order.
- R5: Mode 001 runs eight passes in this order: write 0, check 0, write all-ones, check all-ones, write each address's own value, check it, write the complement of the address in descending order, check it in descending order. At the end, word a holds ~a.
- R6: Mode 110 runs only the last four passes of mode 001.
- R7: A test of S passes clears bit 10 on the (S*2^ADDR_W + 1)-th clock edge after the edge that accepted the start write.
- R8: During a check pass, any read word that differs from the expected value makes the result fail. The sweep still runs to the last address, so the duration is unchanged.
- R9: When bit 14 is set, the test reports fail whatever the RAM holds.
- R10: After master reset, the increment/decrement test (mode 110 sequence) starts on the first clock edge with no host action. The register keeps its mode field at 000 and shows bit 10 = 1 until completion.
- R11: While bit 10 reads 1, host register writes and host RAM accesses are ignored.
- R12: With bit 15 clear, a host write to an address below PROT_LIMIT leaves the bits set in PROT_MASK unchanged. With bit 15 set, or at higher addresses, all bits are written.
- R13: A write-only mode (010 or 100) reports pass unless failure is forced. When idle, a host read returns the RAM word one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 16 | Control register write value |
| reg_rd_data | output | 16 | Control register read value |
| host_addr | input | ADDR_W | Host RAM address |
| host_wdata | input | DATA_W | Host RAM write data |
| host_we | input | 1 | Host RAM write strobe |
| host_re | input | 1 | Host RAM read strobe |
| host_rdata | output | DATA_W | RAM read data returned to the host |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_wbe | output | DATA_W | RAM per-bit write enable |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after ram_re |

## Verification
The assertions assume three things about the RAM and the host:
- The RAM returns read data exactly one cycle after the read strobe.
- The host never tries to start a test while one is already running.
- The host does not expect its RAM accesses to take effect during a test.

The stimulus keeps within these limits. The bench's RAM model has fixed one-cycle latency. Every test start is followed by a wait until bit 10 reads 0. Host accesses made during a run are there only to show that they are discarded. A stuck-bit fault switched into the RAM model's read path gives the mismatch path real failures to report.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    PAT_ZERO,
    PAT_ONES,
    PAT_ADDR,
    PAT_NADDR
  } pat_e;

  typedef struct packed {
    logic rd;
    logic down;
    pat_e pat;
  } step_t;

  localparam logic [2:0] MODE_INCDEC = 3'b110;

  function automatic step_t step_info(input logic [2:0] idx);
    step_t s;
    unique case (idx)
      3'd0: s = '{rd: 1'b0, down: 1'b0, pat: PAT_ZERO};
      3'd1: s = '{rd: 1'b1, down: 1'b0, pat: PAT_ZERO};
      3'd2: s = '{rd: 1'b0, down: 1'b0, pat: PAT_ONES};
      3'd3: s = '{rd: 1'b1, down: 1'b0, pat: PAT_ONES};
      3'd4: s = '{rd: 1'b0, down: 1'b0, pat: PAT_ADDR};
      3'd5: s = '{rd: 1'b1, down: 1'b0, pat: PAT_ADDR};
      3'd6: s = '{rd: 1'b0, down: 1'b1, pat: PAT_NADDR};
      default: s = '{rd: 1'b1, down: 1'b1, pat: PAT_NADDR};
    endcase
    return s;
  endfunction

  function automatic logic mode_runs(input logic [2:0] mode);
    return (mode != 3'b000) && (mode != 3'b111);
  endfunction

  function automatic logic [2:0] mode_first(input logic [2:0] mode);
    unique case (mode)
      3'b011: return 3'd1;
      3'b100: return 3'd2;
      3'b101: return 3'd3;
      3'b110: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] mode_last(input logic [2:0] mode);
    unique case (mode)
      3'b001: return 3'd7;
      3'b011: return 3'd1;
      3'b100: return 3'd2;
      3'b101: return 3'd3;
      3'b110: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rt_ctrl_reg.sv
module rt_ctrl_reg
  import rt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:10] wr_bits,
  input  logic        done,
  input  logic        done_fail,
  output logic [15:0] rd_data,
  output logic        full_acc,
  output logic        force_fail,
  output logic        run,
  output logic        start,
  output logic [2:0]  start_mode
);

  logic       auto_q;
  logic       full_q, force_q, run_q;
  logic [2:0] mode_q;
  logic [1:0] res_q;
  logic       wr_ok, host_start;

  assign wr_ok      = wr_en && !run_q && !auto_q;
  assign host_start = wr_ok && wr_bits[10] && mode_runs(wr_bits[13:11]);
  assign start      = host_start || auto_q;
  assign start_mode = auto_q ? MODE_INCDEC : wr_bits[13:11];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b1;
      full_q  <= 1'b0;
      force_q <= 1'b0;
      mode_q  <= 3'b000;
      run_q   <= 1'b0;
      res_q   <= 2'b00;
    end else begin
      auto_q <= 1'b0;
      if (wr_ok) begin
        full_q  <= wr_bits[15];
        force_q <= wr_bits[14];
        mode_q  <= wr_bits[13:11];
      end
      if (start) begin
        run_q <= 1'b1;
        res_q <= 2'b00;
      end else if (done) begin
        run_q <= 1'b0;
        res_q <= done_fail ? 2'b01 : 2'b10;
      end
    end
  end

  assign rd_data    = {full_q, force_q, mode_q, run_q, res_q, 8'h00};
  assign full_acc   = full_q;
  assign force_fail = force_q;
  assign run        = run_q;

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run_q && (res_q == 2'b00));
  // R2
  done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !run_q && $onehot(res_q));
  // R2
  done_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_q);
  // R9
  force_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && force_q |=> res_q == 2'b01);
  // R11
  host_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && wr_en |=> $stable({full_q, force_q, mode_q}));

endmodule

// File: rtl/rt_seq.sv
module rt_seq
  import rt_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        start_mode,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic              acc_we,
  output logic              acc_re,
  output logic              last_acc,
  output logic              active
);

  logic              active_q;
  logic [2:0]        step_q, last_step_q;
  logic [ADDR_W-1:0] cnt_q;
  step_t             info;
  logic              step_end;

  function automatic logic [DATA_W-1:0] pat_word(input pat_e p,
                                                 input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] ext;
    ext = DATA_W'(a);
    unique case (p)
      PAT_ZERO:  return '0;
      PAT_ONES:  return '1;
      PAT_ADDR:  return ext;
      default:   return ~ext;
    endcase
  endfunction

  assign info     = step_info(step_q);
  assign acc_addr = info.down ? ~cnt_q : cnt_q;
  assign acc_data = pat_word(info.pat, acc_addr);
  assign acc_we   = active_q && !info.rd;
  assign acc_re   = active_q && info.rd;
  assign step_end = active_q && (&cnt_q);
  assign last_acc = step_end && (step_q == last_step_q);
  assign active   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      step_q      <= 3'd0;
      last_step_q <= 3'd0;
      cnt_q       <= '0;
    end else if (start) begin
      active_q    <= 1'b1;
      step_q      <= mode_first(start_mode);
      last_step_q <= mode_last(start_mode);
      cnt_q       <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (step_end) step_q <= step_q + 1'b1;
      if (last_acc) active_q <= 1'b0;
    end
  end

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !last_acc |=> cnt_q == $past(cnt_q) + 1'b1);
  // R5
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !step_end |=> step_q == $past(step_q));
  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> step_q <= last_step_q);

endmodule

// File: rtl/rt_cmp.sv
module rt_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] exp_in,
  input  logic              last_in,
  input  logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              failed
);

  logic              vld_q, fin_q, err_q;
  logic [DATA_W-1:0] exp_q;
  logic              mismatch;

  assign mismatch = vld_q && (rdata != exp_q);
  assign done     = fin_q;
  assign failed   = err_q || mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      fin_q <= 1'b0;
      err_q <= 1'b0;
      exp_q <= '0;
    end else if (clear) begin
      vld_q <= 1'b0;
      fin_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= rd_issue;
      exp_q <= exp_in;
      fin_q <= last_in;
      if (mismatch) err_q <= 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clear |=> err_q);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);

endmodule

// File: rtl/ram_selftest.sv
module ram_selftest #(
  parameter int              ADDR_W     = 15,
  parameter int              DATA_W     = 16,
  parameter int              PROT_LIMIT = 512,
  parameter logic [DATA_W-1:0] PROT_MASK = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [15:0]       reg_wr_data,
  output logic [15:0]       reg_rd_data,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_re,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] ram_wbe,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata
);

  localparam logic [ADDR_W-1:0] PROT_END = ADDR_W'(PROT_LIMIT);

  logic              full_acc, force_fail, run, start;
  logic [2:0]        start_mode;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_data, host_wbe;
  logic              eng_we, eng_re, eng_last, eng_active;
  logic              cmp_done, cmp_fail;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^reg_wr_data[9:0];

  rt_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_bits    (reg_wr_data[15:10]),
    .done       (cmp_done),
    .done_fail  (force_fail || cmp_fail),
    .rd_data    (reg_rd_data),
    .full_acc   (full_acc),
    .force_fail (force_fail),
    .run        (run),
    .start      (start),
    .start_mode (start_mode)
  );

  rt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_mode (start_mode),
    .acc_addr   (eng_addr),
    .acc_data   (eng_data),
    .acc_we     (eng_we),
    .acc_re     (eng_re),
    .last_acc   (eng_last),
    .active     (eng_active)
  );

  rt_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .rd_issue (eng_re),
    .exp_in   (eng_data),
    .last_in  (eng_last),
    .rdata    (ram_rdata),
    .done     (cmp_done),
    .failed   (cmp_fail)
  );

  assign host_wbe = (full_acc || host_addr >= PROT_END) ? '1 : ~PROT_MASK;

  always_comb begin
    if (run) begin
      ram_addr  = eng_addr;
      ram_wdata = eng_data;
      ram_wbe   = '1;
      ram_we    = eng_we;
      ram_re    = eng_re;
    end else begin
      ram_addr  = host_addr;
      ram_wdata = host_wdata;
      ram_wbe   = host_wbe;
      ram_we    = host_we;
      ram_re    = host_re;
    end
  end

  assign host_rdata = ram_rdata;

  // R11
  tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !eng_active |-> !ram_we && !ram_re);
  // R12
  engine_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> &ram_wbe);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !eng_we);

endmodule

// File: tb/ram_selftest_test.sv
module ram_selftest_test;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 1 << AW;
  localparam logic [15:0] PMASK = 16'hF000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [15:0]   reg_wr_data = '0;
  logic [15:0]   reg_rd_data;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_we = 1'b0, host_re = 1'b0;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_wbe, ram_rdata;
  logic          ram_we, ram_re;

  logic [DW-1:0] mem [NW];
  logic          flt = 1'b0;
  int            total = 0, fails = 0;

  always #4 clk = ~clk;

  ram_selftest #(.ADDR_W(AW), .DATA_W(DW), .PROT_LIMIT(8), .PROT_MASK(PMASK)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_wbe(ram_wbe),
    .ram_we(ram_we), .ram_re(ram_re), .ram_rdata(ram_rdata)
  );

  // RAM model: one-cycle read latency; optional stuck-at-0 on bit 0 of word 9
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= (mem[ram_addr] & ~ram_wbe) | (ram_wdata & ram_wbe);
    if (ram_re) ram_rdata <= (flt && ram_addr == 6'd9) ? (mem[ram_addr] & 16'hFFFE)
                                                      : mem[ram_addr];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (reg_rd_data[10] && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  // {mode[10:8], force[7], fault[6], result[5:4], passes[3:0]}; result 10 = pass, 01 = fail
  localparam logic [10:0] VEC [14] = '{
    {3'b010, 1'b0, 1'b0, 2'b10, 4'd1},
    {3'b011, 1'b0, 1'b0, 2'b10, 4'd1},
    {3'b100, 1'b0, 1'b0, 2'b10, 4'd1},
    {3'b101, 1'b0, 1'b0, 2'b10, 4'd1},
    {3'b001, 1'b0, 1'b0, 2'b10, 4'd8},
    {3'b110, 1'b0, 1'b0, 2'b10, 4'd4},
    {3'b110, 1'b0, 1'b1, 2'b01, 4'd4},
    {3'b010, 1'b0, 1'b1, 2'b10, 4'd1},
    {3'b011, 1'b0, 1'b1, 2'b10, 4'd1},
    {3'b101, 1'b0, 1'b1, 2'b01, 4'd1},
    {3'b100, 1'b0, 1'b1, 2'b10, 4'd1},
    {3'b010, 1'b1, 1'b0, 2'b01, 4'd1},
    {3'b011, 1'b1, 1'b0, 2'b01, 4'd1},
    {3'b001, 1'b0, 1'b1, 2'b01, 4'd8}
  };

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 16'h5A5A;
  end

  initial begin : watchdog
    #(8 * 150000);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int cyc;
    int acc;
    logic [DW-1:0] rd;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset reg", reg_rd_data, 16'h0000);
    check("R1 reset no write", ram_we, 1'b0);

    // R10 automatic inc/dec test after reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 auto run bit", reg_rd_data[10], 1'b1);
    wait_done(cyc);
    check("R10 R7 auto duration", cyc, 4 * NW + 1);
    check("R10 auto result", reg_rd_data, 16'h0200);
    host_read(6'd3, rd);
    check("R5 R13 auto leaves ~addr", rd, 16'hFFFC);
    host_read(6'd63, rd);
    check("R6 auto leaves ~addr top", rd, 16'hFFC0);

    // R2 R4 R5 R6 R7 R8 R9 R13 vector table
    for (int v = 0; v < 14; v++) begin
      logic [2:0] m;
      logic       frc;
      m   = VEC[v][10:8];
      frc = VEC[v][7];
      flt = VEC[v][6];
      reg_write({1'b0, frc, m, 1'b1, 10'h000});
      check($sformatf("R2 vec%0d run set, result cleared", v),
            reg_rd_data[10:8], 3'b100);
      wait_done(cyc);
      check($sformatf("R7 R8 vec%0d duration", v), cyc, VEC[v][3:0] * NW + 1);
      check($sformatf("R2 R4 R9 vec%0d register", v), reg_rd_data,
            {1'b0, frc, m, 1'b0, VEC[v][5:4], 8'h00});
    end
    flt = 1'b0;

    // R3 idle codes
    acc = 0;
    reg_write(16'h0400);
    repeat (4) begin @(negedge clk); acc += int'(ram_we) + int'(ram_re); end
    check("R3 idle 000 register", reg_rd_data, 16'h0100);
    reg_write(16'h3C00);
    repeat (4) begin @(negedge clk); acc += int'(ram_we) + int'(ram_re); end
    check("R3 idle 111 register", reg_rd_data, 16'h3900);
    check("R3 idle no RAM access", acc, 0);

    // R11 host ignored while busy
    reg_write(16'h0C00);
    host_write(6'd5, 16'h1234);
    reg_write(16'h0000);
    check("R11 reg write ignored", reg_rd_data, 16'h0C00);
    wait_done(cyc);
    check("R11 R5 pass after busy writes", reg_rd_data, 16'h0A00);
    host_read(6'd5, rd);
    check("R11 host RAM write ignored", rd, 16'hFFFA);

    // R12 write masking and full access
    reg_write(16'h1400);
    wait_done(cyc);
    host_write(6'd2, 16'hFFFF);
    host_read(6'd2, rd);
    check("R12 protected bits masked", rd, 16'h0FFF);
    host_write(6'd20, 16'hFFFF);
    host_read(6'd20, rd);
    check("R12 above limit unmasked", rd, 16'hFFFF);
    reg_write(16'h8000);
    check("R12 R1 full access bit", reg_rd_data, 16'h8200);
    host_write(6'd2, 16'hABCD);
    host_read(6'd2, rd);
    check("R12 full access write", rd, 16'hABCD);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule